// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog peripheral for a processor subsystem. A 32-bit down-counter steps once per microsecond. The microsecond tick comes from an internal prescaler that divides the system clock. Software programs a reload value and a control word through a small register port. It keeps the counter from running out by writing a fixed 32-bit key to the restart register. A restart write with any other value is ignored.

When the counter is enabled and a tick arrives while the count is zero, the block reloads the counter from the reload register. It also emits a one-cycle timeout event. The event can do three things, each gated by its own control bit:

- raise a latched interrupt;
- issue a one-cycle reset strobe, which carries a two-bit reset-scope code;
- issue a one-cycle strobe toward an external pulse generator.

A status register records that a timeout happened. It separately records that a timeout happened while the secondary-boot request was set. Software clears these flags by writing ones to them.

Top module: `keyed_watchdog`

## Requirements
- R1: After synchronous reset, the count, reload, control and status registers all read 0, and irq, rst_req and ext_evt are low.
- R2: Register offsets (addr) are: 0x00 count (read-only), 0x04 reload (read/write), 0x08 restart (write-only, reads 0), 0x0C control (bits 7:0, upper bits read 0), 0x10 status. Any other offset reads 0.
- R3: A write of exactly 32'h0000_4755 to offset 0x08 loads the count with the reload value on the next clock. Any other value written there leaves the count unchanged.
- R4: While control bit 0 is set, the count decrements by one on each microsecond tick. The tick comes once every CLK_HZ/TICK_HZ system clocks; the first tick is on the (CLK_HZ/TICK_HZ)-th clock edge after reset is released.
- R5: While control bit 0 is clear, the count holds its value. Setting the bit again resumes counting from the held value.
- R6: A tick while enabled with the count at 0 reloads the count from the reload register and produces one timeout event in the following cycle.
- R7: On a timeout event with control bit 1 set, rst_req is high for exactly one cycle. rst_scope always shows control bits 6:5 (0 = SoC, 1 = full chip, 2 = CPU only).
- R8: On a timeout event with control bit 3 set, ext_evt is high for exactly one cycle. With bit 3 clear it stays low.
- R9: A timeout event with control bit 2 set sets status bit 0, which drives irq. The flag stays set until status is written with bit 0 = 1.
- R10: A timeout event with control bit 7 set sets status bit 1. The flag stays set until status is written with bit 1 = 1.
- R11: A valid restart write in the same cycle as a tick takes priority: the count loads the reload value rather than decrementing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Latched timeout interrupt |
| rst_req | output | 1 | One-cycle reset request strobe |
| rst_scope | output | 2 | Reset scope code accompanying rst_req |
| ext_evt | output | 1 | One-cycle strobe toward the external pulse generator |

## Verification
Some properties are checked by assertions on every cycle:

- the tick is a single-cycle pulse;
- the count only steps down by one on an enabled tick;
- the count is frozen while disabled;
- a key write reloads the count;
- the timeout event, reset strobe and external strobe are each one cycle wide;
- the interrupt flag persists until it is cleared.

Other behaviour is shown only by the bench scenarios, which compare every output against a behavioural model on every clock:

- non-key restart values are rejected;
- the reset-scope code follows the control field;
- the secondary-boot flag is set and cleared;
- a key write that lands on a tick edge wins over the decrement.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int CNT_W  = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_RELOAD  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RESTART = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'h10;

    localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

    typedef enum logic [1:0] {
        SCOPE_SOC  = 2'd0,
        SCOPE_CHIP = 2'd1,
        SCOPE_CPU  = 2'd2,
        SCOPE_RSVD = 2'd3
    } scope_e;

    typedef struct packed {
        logic   alt_boot;  // bit 7
        scope_e scope;     // bits 6:5
        logic   tick_sel;  // bit 4
        logic   ext_en;    // bit 3
        logic   irq_en;    // bit 2
        logic   rst_en;    // bit 1
        logic   run;       // bit 0
    } ctrl_t;

    typedef struct packed {
        logic alt_hit;     // bit 1
        logic tmo_hit;     // bit 0
    } status_t;

    function automatic logic is_restart_key(input logic [ADDR_W-1:0] a,
                                            input logic [31:0] d);
        return (a == OFS_RESTART) && (d == RESTART_KEY);
    endfunction

endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R4

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             key_hit,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic at_zero;
    assign at_zero = (count == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (key_hit) begin
                count <= reload;
            end else if (run && tick) begin
                if (at_zero) begin
                    count  <= reload;
                    expire <= 1'b1;
                end else begin
                    count <= count - 1'b1;
                end
            end
        end
    end

    AST_KEY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        key_hit |=> count == $past(reload)); // R3
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && !key_hit) |=> $stable(count)); // R5
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !key_hit && count != '0) |=> count == $past(count) - 1'b1); // R4
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire); // R6

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              key_hit,
    output logic [31:0]       rdata,
    output logic              irq,
    output logic              rst_req,
    output logic [1:0]        rst_scope,
    output logic              ext_evt
);
    status_t status;
    logic    ctrl_wr, reload_wr, status_wr;
    status_t clr;

    assign ctrl_wr   = wr_en && (addr == OFS_CTRL);
    assign reload_wr = wr_en && (addr == OFS_RELOAD);
    assign status_wr = wr_en && (addr == OFS_STATUS);
    assign key_hit   = wr_en && is_restart_key(addr, wdata);
    assign clr       = status_wr ? status_t'(wdata[1:0]) : status_t'(2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            status <= '0;
        end else begin
            if (ctrl_wr)   ctrl   <= ctrl_t'(wdata[7:0]);
            if (reload_wr) reload <= wdata;
            status.tmo_hit <= (status.tmo_hit & ~clr.tmo_hit) | (expire & ctrl.irq_en);
            status.alt_hit <= (status.alt_hit & ~clr.alt_hit) | (expire & ctrl.alt_boot);
        end
    end

    always_comb begin
        unique case (addr)
            OFS_COUNT:  rdata = count;
            OFS_RELOAD: rdata = reload;
            OFS_CTRL:   rdata = {24'd0, ctrl};
            OFS_STATUS: rdata = {30'd0, status};
            default:    rdata = '0;
        endcase
    end

    assign irq       = status.tmo_hit;
    assign rst_req   = expire & ctrl.rst_en;
    assign ext_evt   = expire & ctrl.ext_en;
    assign rst_scope = ctrl.scope;

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req); // R7
    AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ext_evt |=> !ext_evt); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !(status_wr && wdata[0])) |=> irq); // R9
    AST_ALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (status.alt_hit && !(status_wr && wdata[1])) |=> status.alt_hit); // R10

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int CLK_HZ  = 50_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq,
    output logic        rst_req,
    output logic [1:0]  rst_scope,
    output logic        ext_evt
);
    localparam int DIV = CLK_HZ / TICK_HZ;

    logic             tick;
    logic             key_hit;
    logic             expire;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] reload;
    ctrl_t            ctrl;

    kwd_prescaler #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    kwd_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .run     (ctrl.run),
        .key_hit (key_hit),
        .reload  (reload),
        .count   (count),
        .expire  (expire)
    );

    kwd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .count     (count),
        .expire    (expire),
        .ctrl      (ctrl),
        .reload    (reload),
        .key_hit   (key_hit),
        .rdata     (rdata),
        .irq       (irq),
        .rst_req   (rst_req),
        .rst_scope (rst_scope),
        .ext_evt   (ext_evt)
    );

endmodule

// File: tb/tb_keyed_watchdog.sv
`timescale 1ns/1ps
module tb_keyed_watchdog;
    localparam int DIV = 50;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req, ext_evt;
    logic [1:0]  rst_scope;

    int checks = 0;
    int errors = 0;
    int ext_pulses = 0;
    int rst_pulses = 0;

    keyed_watchdog dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq), .rst_req(rst_req), .rst_scope(rst_scope),
        .ext_evt(ext_evt)
    );

    always #2 clk = ~clk;

    // behavioural reference model
    int          m_pre;
    logic [31:0] m_cnt, m_rel;
    logic [7:0]  m_ctrl;
    logic        m_exp, m_irq, m_alt;

    always @(posedge clk) begin
        bit t, ex;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_rel = 0; m_ctrl = 0;
            m_exp = 0; m_irq = 0; m_alt = 0;
        end else begin
            t = (m_pre == DIV - 1);
            m_pre = t ? 0 : m_pre + 1;
            ex = 0;
            if (wr_en && addr == 5'h08 && wdata == 32'h4755) m_cnt = m_rel;
            else if (m_ctrl[0] && t) begin
                if (m_cnt == 0) begin m_cnt = m_rel; ex = 1; end
                else m_cnt = m_cnt - 1;
            end
            m_irq = (m_irq && !(wr_en && addr == 5'h10 && wdata[0])) || (m_exp && m_ctrl[2]);
            m_alt = (m_alt && !(wr_en && addr == 5'h10 && wdata[1])) || (m_exp && m_ctrl[7]);
            if (wr_en && addr == 5'h04) m_rel = wdata;
            if (wr_en && addr == 5'h0C) m_ctrl = wdata[7:0];
            m_exp = ex;
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_cnt;
            5'h04: return m_rel;
            5'h0C: return {24'd0, m_ctrl};
            5'h10: return {30'd0, m_alt, m_irq};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            check("R2 R4 R6 rdata", rdata, m_read(addr));
            check("R9 irq", {31'd0, irq}, {31'd0, m_irq});
            check("R7 rst_req", {31'd0, rst_req}, {31'd0, m_exp & m_ctrl[1]});
            check("R7 rst_scope", {30'd0, rst_scope}, {30'd0, m_ctrl[6:5]});
            check("R8 ext_evt", {31'd0, ext_evt}, {31'd0, m_exp & m_ctrl[3]});
            if (ext_evt) ext_pulses++;
            if (rst_req) rst_pulses++;
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd_check("R1 count", 5'h00, 32'd0);
        rd_check("R1 reload", 5'h04, 32'd0);
        rd_check("R1 ctrl", 5'h0C, 32'd0);
        rd_check("R1 status", 5'h10, 32'd0);
        check("R1 outputs", {29'd0, irq, rst_req, ext_evt}, 32'd0);
        // R2 unmapped and write-only offsets
        rd_check("R2 restart reads 0", 5'h08, 32'd0);
        rd_check("R2 unmapped", 5'h14, 32'd0);
        // R3 key filtering
        wr(5'h04, 32'd3);
        wr(5'h08, 32'h0000_1234);
        rd_check("R3 wrong key", 5'h00, 32'd0);
        wr(5'h08, 32'h0001_4755);
        rd_check("R3 upper bits set", 5'h00, 32'd0);
        wr(5'h08, 32'h0000_4755);
        rd_check("R3 key reload", 5'h00, 32'd3);
        // R4 R6 R7 R8 R9: run with all actions, scope full chip
        wr(5'h0C, 32'h0000_002F);
        idle(6 * DIV);
        rd_check("R9 irq latched", 5'h10, 32'd1);
        check("R8 ext pulses seen", {31'd0, ext_pulses > 0}, 32'd1);
        check("R7 rst pulses seen", {31'd0, rst_pulses > 0}, 32'd1);
        // R5 freeze
        wr(5'h0C, 32'h0000_002E);
        @(negedge clk); addr = 5'h00; #1; held = rdata;
        idle(3 * DIV);
        rd_check("R5 frozen", 5'h00, held);
        // R9 clear
        wr(5'h10, 32'h0000_0001);
        rd_check("R9 cleared", 5'h10, 32'd0);
        check("R9 irq low", {31'd0, irq}, 32'd0);
        // R5 resume, R7 scope CPU
        wr(5'h0C, 32'h0000_004B);
        idle(6 * DIV);
        check("R7 scope cpu", {30'd0, rst_scope}, 32'd2);
        // R8 ext disabled: no more pulses
        wr(5'h0C, 32'h0000_0003);
        ext_pulses = 0;
        idle(6 * DIV);
        check("R8 ext stays low", ext_pulses, 32'd0);
        // R10 secondary-boot flag
        wr(5'h0C, 32'h0000_0081);
        idle(6 * DIV);
        rd_check("R10 alt flag", 5'h10, 32'd2);
        wr(5'h0C, 32'h0000_0000);
        wr(5'h10, 32'h0000_0002);
        rd_check("R10 alt cleared", 5'h10, 32'd0);
        // R11 key on a tick edge
        wr(5'h04, 32'd10);
        wr(5'h08, 32'h0000_4755);
        wr(5'h0C, 32'h0000_0001);
        idle(2 * DIV);
        while (m_pre != DIV - 1) @(negedge clk);
        wr_en = 1'b1; addr = 5'h08; wdata = 32'h0000_4755;
        @(negedge clk);
        wr_en = 1'b0; addr = 5'h00;
        #1;
        check("R11 key beats tick", rdata, 32'd10);
        idle(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule